// File: doc/BRIEF.md
# Snooping Four-State Cache-Line Coherence Controller

This block keeps the coherence state of one cache line on a shared, snooped bus where caches write back and invalidate. The line holds one of four states: Invalid (`ST_INV`), Exclusive-clean (`ST_EXC`), Shared (`ST_SHR`) and Modified (`ST_MOD`). The controller takes three kinds of input:

- processor requests (read, write, evict), which use a valid/done handshake;
- transactions snooped from the bus (shared read, read-for-ownership);
- the sampled wired-OR shared line.

It drives four kinds of output:

- a bus request with a command, which completes on grant;
- a flush strobe for dirty data;
- its own contribution to the shared line;
- the current line state.

A read miss samples the shared line in the grant cycle. If no other cache claims a copy, the line is filled as exclusive-clean. A later write to that line then becomes Modified without any bus traffic, so a lone reader that then writes costs one bus transaction, not two.

Transitions: processor read miss `ST_INV→ST_EXC/ST_SHR`; read-for-ownership `ST_INV/ST_SHR→ST_MOD`; silent upgrade `ST_EXC→ST_MOD`; local hits stay put; snooped shared read `ST_MOD→ST_SHR` (flush) and `ST_EXC→ST_SHR`; snooped read-for-ownership `ST_MOD→ST_INV` (flush) and `ST_EXC/ST_SHR→ST_INV`; evict `ST_MOD→ST_INV` via write-back, `ST_EXC/ST_SHR→ST_INV` silently.

A snoop always takes the cycle it arrives in. A processor request that is waiting in that cycle is stalled and is judged again in the next cycle against the updated state.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset the line state is Invalid (encoding 0). With all inputs idle, bus_req, flush and shared_out are 0 and bus_cmd is NONE (0).
- R2: A read (op 0) in Invalid drives bus_req with bus_cmd SHRD (1). In the cycle bus_gnt is 1, cpu_done pulses and the state becomes Exclusive (1) if shared_in is 0, or Shared (2) if shared_in is 1.
- R3: A write (op 1) in Invalid or Shared drives bus_cmd OWN (2). When granted, the state becomes Modified (3).
- R4: A write in Exclusive completes in the same cycle with no bus_req, and the state becomes Modified.
- R5: A read in Exclusive, Shared or Modified, and a write in Modified, complete in the same cycle with no bus_req and leave the state unchanged.
- R6: A snooped shared read (snp_cmd 1) in Modified asserts flush in that cycle and moves the line to Shared.
- R7: A snooped read-for-ownership (snp_cmd 2) moves any valid line to Invalid. It asserts flush only when the line was Modified.
- R8: shared_out is 1 during a snooped shared read whenever the line is valid and 0 when it is Invalid. A snooped shared read moves Exclusive to Shared without a flush.
- R9: An evict (op 2) in Modified requests a write-back (bus_cmd WB, 3) and becomes Invalid on grant. An evict in Exclusive or Shared becomes Invalid in the same cycle with no bus_req.
- R10: In a cycle with snp_vld, cpu_done and bus_req are 0 and bus_gnt is ignored. A request still held is re-evaluated in the next cycle against the post-snoop state.
- R11: A bus-needing request stays pending, with cpu_done 0 and bus_req held, until bus_gnt. Op 3 completes at once with no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_vld | input | 1 | Processor request held until cpu_done |
| cpu_req_op | input | 2 | 0 read, 1 write, 2 evict, 3 no-op |
| cpu_done | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | 0 none, 1 shared read, 2 read-for-ownership, 3 write-back |
| bus_gnt | input | 1 | Arbiter grant for the current request |
| shared_in | input | 1 | Sampled wired-OR shared line |
| snp_vld | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | 1 shared read, 2 read-for-ownership |
| flush | output | 1 | Dirty data supplied to the bus this cycle |
| shared_out | output | 1 | Contribution to the shared line |
| line_state | output | 2 | 0 I, 1 E, 2 S, 3 M |

## Verification
The delicate overlap is a snoop landing in the same cycle that the arbiter grants the line's own pending request. The bench provokes it twice:

- A write held in Shared meets a snooped read-for-ownership together with a grant. The write must neither complete nor request the bus, and the line must drop to Invalid. On the next cycle the write reissues as a read-for-ownership.
- A write held in Exclusive meets a snooped shared read. The silent upgrade must be withheld, and the write must return as a bus request from Shared.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_EXC = 2'd1,
        ST_SHR = 2'd2,
        ST_MOD = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        OP_RD   = 2'd0,
        OP_WR   = 2'd1,
        OP_EVT  = 2'd2,
        OP_NOP  = 2'd3
    } cpu_op_t;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_SHRD = 2'd1,
        BC_OWN  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_t;
endpackage

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
(
    input  line_st_t   cur_st,
    input  logic       snp_vld,
    input  bus_cmd_t   snp_cmd,
    output line_st_t   snp_nxt,
    output logic       snp_flush,
    output logic       snp_shared
);
    always_comb begin
        snp_nxt    = cur_st;
        snp_flush  = 1'b0;
        snp_shared = 1'b0;
        if (snp_vld) begin
            unique case (snp_cmd)
                BC_SHRD: begin
                    snp_shared = (cur_st != ST_INV);
                    if (cur_st == ST_MOD) begin
                        snp_flush = 1'b1;
                        snp_nxt   = ST_SHR;
                    end else if (cur_st == ST_EXC) begin
                        snp_nxt   = ST_SHR;
                    end
                end
                BC_OWN: begin
                    snp_flush = (cur_st == ST_MOD);
                    snp_nxt   = ST_INV;
                end
                default: begin
                    snp_nxt = cur_st;
                end
            endcase
        end
    end
endmodule

// File: rtl/mesi_cpu_unit.sv
module mesi_cpu_unit
    import mesi_pkg::*;
(
    input  line_st_t   cur_st,
    input  logic       req_vld,
    input  cpu_op_t    req_op,
    input  logic       stall,
    input  logic       gnt,
    input  logic       shared_in,
    output logic       breq,
    output bus_cmd_t   bcmd,
    output logic       done,
    output line_st_t   cpu_nxt
);
    bus_cmd_t need;

    always_comb begin
        need = BC_NONE;
        unique case (req_op)
            OP_RD:   need = (cur_st == ST_INV) ? BC_SHRD : BC_NONE;
            OP_WR:   need = (cur_st == ST_INV || cur_st == ST_SHR) ? BC_OWN : BC_NONE;
            OP_EVT:  need = (cur_st == ST_MOD) ? BC_WB : BC_NONE;
            default: need = BC_NONE;
        endcase
    end

    always_comb begin
        breq    = req_vld && !stall && (need != BC_NONE);
        bcmd    = breq ? need : BC_NONE;
        done    = req_vld && !stall && ((need == BC_NONE) || gnt);
        cpu_nxt = cur_st;
        if (done) begin
            unique case (req_op)
                OP_RD:   cpu_nxt = (cur_st == ST_INV) ? (shared_in ? ST_SHR : ST_EXC) : cur_st;
                OP_WR:   cpu_nxt = ST_MOD;
                OP_EVT:  cpu_nxt = ST_INV;
                default: cpu_nxt = cur_st;
            endcase
        end
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req_vld,
    input  logic [1:0] cpu_req_op,
    output logic       cpu_done,
    output logic       bus_req,
    output logic [1:0] bus_cmd,
    input  logic       bus_gnt,
    input  logic       shared_in,
    input  logic       snp_vld,
    input  logic [1:0] snp_cmd,
    output logic       flush,
    output logic       shared_out,
    output logic [1:0] line_state
);
    line_st_t st_q;
    line_st_t st_d;
    line_st_t snp_nxt;
    line_st_t cpu_nxt;
    bus_cmd_t bcmd;

    mesi_snoop_unit u_snoop (
        .cur_st     (st_q),
        .snp_vld    (snp_vld),
        .snp_cmd    (bus_cmd_t'(snp_cmd)),
        .snp_nxt    (snp_nxt),
        .snp_flush  (flush),
        .snp_shared (shared_out)
    );

    mesi_cpu_unit u_cpu (
        .cur_st    (st_q),
        .req_vld   (cpu_req_vld),
        .req_op    (cpu_op_t'(cpu_req_op)),
        .stall     (snp_vld),
        .gnt       (bus_gnt),
        .shared_in (shared_in),
        .breq      (bus_req),
        .bcmd      (bcmd),
        .done      (cpu_done),
        .cpu_nxt   (cpu_nxt)
    );

    always_comb begin
        if (snp_vld)       st_d = snp_nxt;
        else if (cpu_done) st_d = cpu_nxt;
        else               st_d = st_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_INV;
        else        st_q <= st_d;
    end

    assign bus_cmd    = bcmd;
    assign line_state = st_q;

    a_r2_fill_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == 2'd1 && !shared_in) |=> (line_state == 2'd1));
    a_r2_fill_shr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == 2'd1 && shared_in) |=> (line_state == 2'd2));
    a_r3_own_to_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == 2'd2) |=> (line_state == 2'd3));
    a_r6_flush_to_shr: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_vld && snp_cmd == 2'd1 && line_state == 2'd3) |=> (line_state == 2'd2));
    a_r7_own_snoop_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_vld && snp_cmd == 2'd2) |=> (line_state == 2'd0));
    a_r9_wb_from_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 2'd3) |-> (line_state == 2'd3));
    a_r10_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
        snp_vld |-> (!cpu_done && !bus_req));
    a_r11_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_vld) |=> $stable(line_state));
endmodule

// File: tb/tb_mesi_line_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_line_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_req_vld;
    logic [1:0] cpu_req_op;
    logic       cpu_done;
    logic       bus_req;
    logic [1:0] bus_cmd;
    logic       bus_gnt;
    logic       shared_in;
    logic       snp_vld;
    logic [1:0] snp_cmd;
    logic       flush;
    logic       shared_out;
    logic [1:0] line_state;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mesi_line_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_req_vld(cpu_req_vld), .cpu_req_op(cpu_req_op),
        .cpu_done(cpu_done), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_gnt(bus_gnt),
        .shared_in(shared_in), .snp_vld(snp_vld), .snp_cmd(snp_cmd), .flush(flush),
        .shared_out(shared_out), .line_state(line_state)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] op, input logic g,
                         input logic sh, input logic sv, input logic [1:0] sc);
        @(negedge clk);
        cpu_req_vld = v; cpu_req_op = op; bus_gnt = g;
        shared_in = sh; snp_vld = sv; snp_cmd = sc;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cpu_req_vld = 0; cpu_req_op = 0; bus_gnt = 0;
        shared_in = 0; snp_vld = 0; snp_cmd = 0;
        tick(); tick();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic to_state(input int s);
        do_reset();
        if (s == 1) begin drive(1, 0, 1, 0, 0, 0); tick(); end
        if (s == 2) begin drive(1, 0, 1, 1, 0, 0); tick(); end
        if (s == 3) begin drive(1, 1, 1, 0, 0, 0); tick(); end
        idle();
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R1 state", line_state, 0);
        check("R1 bus_req", bus_req, 0);
        check("R1 bus_cmd", bus_cmd, 0);
        check("R1 flush", flush, 0);
        check("R1 shared_out", shared_out, 0);
    endtask

    task automatic t_read_miss();
        to_state(0);
        drive(1, 0, 0, 0, 0, 0);
        check("R2 cmd", bus_cmd, 1);
        check("R11 wait done", cpu_done, 0);
        check("R11 wait req", bus_req, 1);
        tick();
        check("R11 wait state", line_state, 0);
        drive(1, 0, 1, 0, 0, 0);
        check("R2 done", cpu_done, 1);
        tick();
        check("R2 to E", line_state, 1);
        to_state(0);
        drive(1, 0, 1, 1, 0, 0);
        tick();
        check("R2 to S", line_state, 2);
    endtask

    task automatic t_write_own();
        to_state(0);
        drive(1, 1, 1, 0, 0, 0);
        check("R3 cmd from I", bus_cmd, 2);
        tick();
        check("R3 I to M", line_state, 3);
        to_state(2);
        drive(1, 1, 1, 0, 0, 0);
        check("R3 cmd from S", bus_cmd, 2);
        tick();
        check("R3 S to M", line_state, 3);
    endtask

    task automatic t_write_excl();
        to_state(1);
        drive(1, 1, 0, 0, 0, 0);
        check("R4 no bus", bus_req, 0);
        check("R4 done", cpu_done, 1);
        tick();
        check("R4 E to M", line_state, 3);
    endtask

    task automatic t_hits();
        for (int s = 1; s <= 3; s++) begin
            to_state(s);
            drive(1, 0, 0, 0, 0, 0);
            check("R5 rd hit no bus", bus_req, 0);
            check("R5 rd hit done", cpu_done, 1);
            tick();
            check("R5 rd hit state", line_state, s);
        end
        to_state(3);
        drive(1, 1, 0, 0, 0, 0);
        check("R5 wr hit no bus", bus_req, 0);
        check("R5 wr hit done", cpu_done, 1);
        tick();
        check("R5 wr hit state", line_state, 3);
        drive(1, 3, 0, 0, 0, 0);
        check("R11 nop done", cpu_done, 1);
        tick();
        check("R11 nop state", line_state, 3);
    endtask

    task automatic t_snoop_rd();
        to_state(3);
        drive(0, 0, 0, 0, 1, 1);
        check("R6 flush", flush, 1);
        check("R8 shared M", shared_out, 1);
        tick();
        check("R6 M to S", line_state, 2);
        to_state(1);
        drive(0, 0, 0, 0, 1, 1);
        check("R8 no flush E", flush, 0);
        check("R8 shared E", shared_out, 1);
        tick();
        check("R8 E to S", line_state, 2);
        drive(0, 0, 0, 0, 1, 1);
        check("R8 shared S", shared_out, 1);
        to_state(0);
        drive(0, 0, 0, 0, 1, 1);
        check("R8 no shared I", shared_out, 0);
    endtask

    task automatic t_snoop_own();
        for (int s = 1; s <= 3; s++) begin
            to_state(s);
            drive(0, 0, 0, 0, 1, 2);
            check("R7 flush", flush, (s == 3) ? 1 : 0);
            tick();
            check("R7 to I", line_state, 0);
        end
    endtask

    task automatic t_evict();
        to_state(3);
        drive(1, 2, 0, 0, 0, 0);
        check("R9 wb cmd", bus_cmd, 3);
        drive(1, 2, 1, 0, 0, 0);
        tick();
        check("R9 M to I", line_state, 0);
        for (int s = 1; s <= 2; s++) begin
            to_state(s);
            drive(1, 2, 0, 0, 0, 0);
            check("R9 silent no bus", bus_req, 0);
            check("R9 silent done", cpu_done, 1);
            tick();
            check("R9 silent to I", line_state, 0);
        end
    endtask

    task automatic t_collide();
        to_state(2);
        drive(1, 1, 1, 0, 1, 2);
        check("R10 no done", cpu_done, 0);
        check("R10 no req", bus_req, 0);
        tick();
        check("R10 snoop won", line_state, 0);
        drive(1, 1, 0, 0, 0, 0);
        check("R10 reissue cmd", bus_cmd, 2);
        drive(1, 1, 1, 0, 0, 0);
        tick();
        check("R10 reissue M", line_state, 3);
        to_state(1);
        drive(1, 1, 0, 0, 1, 1);
        check("R10 E upgrade held", cpu_done, 0);
        tick();
        check("R10 E to S", line_state, 2);
        drive(1, 1, 0, 0, 0, 0);
        check("R10 now needs bus", bus_cmd, 2);
        check("R10 pending", cpu_done, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_read_miss();
                t_write_own();
                t_write_excl();
                t_hits();
                t_snoop_rd();
                t_snoop_own();
                t_evict();
                t_collide();
                idle();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=1 expected=0");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule